// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide Static Memory

This block is a 2048-entry, 8-bit static memory with a pin-style front end. Chip select, output gate and write strobe are active-low and asynchronous to the core. The bidirectional data bus is split into an input byte, an output byte and a drive-enable. Every pin, including the supply-good indication, passes through a two-flop synchronizer. Reads, writes and deselection are then decided from the sampled levels and their edges.

Two digital status inputs stand in for the analog power circuitry. The first says whether the supply is within tolerance. While it is not, the memory deselects itself, ignores every pin and keeps its contents. When the supply returns, a lockout holds until chip select or write strobe has stayed inactive for a set number of cycles.

The second input reports a low backup battery at power-up. It arms a one-shot flag. That flag swallows the first write attempt, clears itself, and leaves later writes to behave normally.

A power state machine has the states PWR_FAIL, PWR_RECOVER and PWR_ON. Its transitions are:
- FAIL_TO_RECOVER when the supply is good.
- RECOVER_TO_ON when the inactive-hold count completes.
- ANY_TO_FAIL when the supply is lost.

An access state machine has the states ACC_IDLE, ACC_READ and ACC_WRITE. Its transitions are:
- START_WRITE when select and strobe are both low.
- END_WRITE when either of them rises, which commits the byte.
- ENTER_READ when select is low and the strobe is high.
- DESELECT when select is high.
- FORCE_IDLE whenever the power machine is not in PWR_ON.

Top module: `guarded_byte_ram`

## Requirements
- R1: With power on, select low and strobe high, the block drives `dout_en`=1 and presents the stored byte at `addr` on `dout` while `oe_n` is low. With `oe_n` high it drives `dout_en`=0.
- R2: With power on and both select and strobe low, a write takes place. `oe_n` has no effect on whether the byte is stored.
- R3: A write opens at the later falling of select or strobe and closes at the earlier rising. The stored byte and address are those sampled in the last cycle both were low, so data changed after the close is not stored.
- R4: Pulling the strobe low while the output is driven turns `dout_en` off.
- R5: While `supply_ok` is 0 the block drives `locked`=1 and `dout_en`=0, ignores all pins and keeps stored contents.
- R6: If `batt_low` is 1 when reset ends or when the supply returns, the first write attempt afterwards is discarded and the flag clears. The following write stores normally.
- R7: After the supply returns, `locked` stays 1 until select or strobe has been high for RECOVER_CYCLES consecutive sampled cycles. Holding both low keeps the count at zero.
- R8: During and right after reset `locked`=1 and `dout_en`=0. Reset enters PWR_FAIL.
- R9: With select high, `dout_en`=0 and no write occurs, whatever the strobe and output gate do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus (0 when not driven) |
| dout_en | output | 1 | Bus drive enable |
| supply_ok | input | 1 | 1 while supply is within tolerance |
| batt_low | input | 1 | Battery-low indication sampled at power-up |
| locked | output | 1 | 1 while write-protected or in recovery lockout |

## Verification
The bench changes the data in the middle of a write and ends the write with select rather than the strobe. A design that latched data at the start of the write, or kept sampling after the close, would store the wrong byte.

It tries to write and read during a supply failure, then reads back earlier data. A design that let pins through while unpowered would corrupt contents or drive the bus.

It holds select and strobe low across the supply's return. A design whose recovery counter ignored the pins would unlock early.

Last, it arms the battery-low flag and writes twice to one address. A design that blocked every write, or none, would return the wrong byte.

// File: rtl/gbr_pkg.sv
package gbr_pkg;

    typedef enum logic [1:0] {
        PWR_FAIL    = 2'd0,
        PWR_RECOVER = 2'd1,
        PWR_ON      = 2'd2
    } pwr_state_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_t;

endpackage

// File: rtl/gbr_sync.sv
module gbr_sync #(
    parameter int               WIDTH = 1,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            q      <= INIT;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gbr_power_fsm.sv
module gbr_power_fsm
    import gbr_pkg::*;
#(
    parameter int RECOVER_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_s,
    input  logic ce_s,
    input  logic we_s,
    input  logic batt_low,
    input  logic wr_attempt,
    output logic locked,
    output logic power_on,
    output logic batt_block
);
    localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOVER_CYCLES - 1);

    pwr_state_t       state, state_nx;
    logic [CNT_W-1:0] hold_cnt;
    logic             pins_idle;
    logic             rec_done;

    assign pins_idle = ce_s || we_s;
    assign rec_done  = (hold_cnt == CNT_LAST) && pins_idle;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PWR_FAIL;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!supply_s) begin
            state_nx = PWR_FAIL;
        end else begin
            unique case (state)
                PWR_FAIL:    state_nx = PWR_RECOVER;
                PWR_RECOVER: if (rec_done) state_nx = PWR_ON;
                PWR_ON:      state_nx = PWR_ON;
                default:     state_nx = PWR_FAIL;
            endcase
        end
    end

    // inactive-hold counter for the recovery lockout
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (state != PWR_RECOVER || !pins_idle) begin
            hold_cnt <= '0;
        end else if (hold_cnt != CNT_LAST) begin
            hold_cnt <= hold_cnt + 1'b1;
        end
    end

    // one-shot battery flag
    always_ff @(posedge clk) begin
        if (rst) begin
            batt_block <= batt_low;
        end else if (state == PWR_FAIL && supply_s) begin
            batt_block <= batt_low;
        end else if (wr_attempt) begin
            batt_block <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        locked   = (state != PWR_ON);
        power_on = (state == PWR_ON);
    end
endmodule

// File: rtl/gbr_access_fsm.sv
module gbr_access_fsm
    import gbr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    input  logic              batt_block,
    output logic              dout_en,
    output logic              wr_attempt,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    acc_state_t state, state_nx;
    logic       both_low;
    logic       read_sel;

    assign both_low = !ce_s && !we_s;
    assign read_sel = !ce_s && we_s;

    always_ff @(posedge clk) begin
        if (rst) state <= ACC_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ACC_IDLE;
        end else begin
            unique case (state)
                ACC_IDLE, ACC_READ, ACC_WRITE: begin
                    if (both_low)      state_nx = ACC_WRITE;
                    else if (read_sel) state_nx = ACC_READ;
                    else               state_nx = ACC_IDLE;
                end
                default: state_nx = ACC_IDLE;
            endcase
        end
    end

    // hold address and data from the latest cycle the write window was open
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (both_low) begin
            wr_addr <= addr_s;
            wr_data <= din_s;
        end
    end

    // outputs
    always_comb begin
        dout_en    = enable && (state == ACC_READ) && !oe_s;
        wr_attempt = enable && (state == ACC_WRITE) && !both_low;
        wr_commit  = wr_attempt && !batt_block;
    end
endmodule

// File: rtl/gbr_store.sv
module gbr_store #(
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter bit CLEAR_ON_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    generate
        if (CLEAR_ON_RESET) begin : g_clear
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
                end else if (wr_en) begin
                    cells[wr_addr] <= wr_data;
                end
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (wr_en && !rst) cells[wr_addr] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/guarded_byte_ram.sv
module guarded_byte_ram
    import gbr_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter int RECOVER_CYCLES = 64,
    parameter bit CLEAR_ON_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              supply_ok,
    input  logic              batt_low,
    output logic              locked
);
    localparam int BUS_W = 3 + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] BUS_INIT = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUS_W-1:0]  bus_s;
    logic              ce_s, oe_s, we_s, supply_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              power_on, batt_block;
    logic              wr_attempt, wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    gbr_sync #(.WIDTH(BUS_W), .INIT(BUS_INIT)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ce_n, oe_n, we_n, addr, din}),
        .q   (bus_s)
    );

    gbr_sync #(.WIDTH(1), .INIT(1'b0)) u_supply_sync (
        .clk (clk),
        .rst (rst),
        .d   (supply_ok),
        .q   (supply_s)
    );

    assign {ce_s, oe_s, we_s, addr_s, din_s} = bus_s;

    gbr_power_fsm #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_power (
        .clk        (clk),
        .rst        (rst),
        .supply_s   (supply_s),
        .ce_s       (ce_s),
        .we_s       (we_s),
        .batt_low   (batt_low),
        .wr_attempt (wr_attempt),
        .locked     (locked),
        .power_on   (power_on),
        .batt_block (batt_block)
    );

    gbr_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_access (
        .clk        (clk),
        .rst        (rst),
        .enable     (power_on),
        .ce_s       (ce_s),
        .we_s       (we_s),
        .oe_s       (oe_s),
        .addr_s     (addr_s),
        .din_s      (din_s),
        .batt_block (batt_block),
        .dout_en    (dout_en),
        .wr_attempt (wr_attempt),
        .wr_commit  (wr_commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    gbr_store #(
        .ADDR_W         (ADDR_W),
        .DATA_W         (DATA_W),
        .CLEAR_ON_RESET (CLEAR_ON_RESET)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_commit),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_s),
        .rd_data (rd_data)
    );

    assign dout = dout_en ? rd_data : '0;
endmodule

// File: rtl/gbr_checker.sv
module gbr_checker (
    input logic clk,
    input logic rst,
    input logic locked,
    input logic dout_en,
    input logic wr_commit,
    input logic wr_attempt,
    input logic batt_block,
    input logic supply_s,
    input logic ce_s,
    input logic we_s
);
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        locked |-> !dout_en);                                   // R5
    AST_LOCK_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        locked |-> !wr_commit);                                 // R5
    AST_FAIL_LOCKS: assert property (@(posedge clk) disable iff (rst)
        !supply_s |=> locked);                                  // R5
    AST_WE_KILLS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!we_s && !ce_s) |=> !dout_en);                         // R4
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        ce_s |=> !dout_en);                                     // R9
    AST_BATT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_attempt |=> !batt_block);                            // R6
    AST_UNLOCK_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(supply_s));                     // R7
endmodule

bind guarded_byte_ram gbr_checker u_gbr_checker (
    .clk        (clk),
    .rst        (rst),
    .locked     (locked),
    .dout_en    (dout_en),
    .wr_commit  (wr_commit),
    .wr_attempt (wr_attempt),
    .batt_block (batt_block),
    .supply_s   (supply_s),
    .ce_s       (ce_s),
    .we_s       (we_s)
);

// File: tb/guarded_byte_ram_test.sv
module guarded_byte_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int REC        = 16;
    localparam int NVEC       = 10;
    // {is_write, address, data}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 11'h000, 8'hA5}, {1'b1, 11'h7FF, 8'h5A},
        {1'b1, 11'h123, 8'hFF}, {1'b1, 11'h400, 8'h00},
        {1'b0, 11'h000, 8'hA5}, {1'b0, 11'h7FF, 8'h5A},
        {1'b0, 11'h123, 8'hFF}, {1'b0, 11'h400, 8'h00},
        {1'b1, 11'h000, 8'h11}, {1'b0, 11'h000, 8'h11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        supply_ok = 1'b1;
    logic        batt_low = 1'b0;
    logic        locked;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    guarded_byte_ram #(.RECOVER_CYCLES(REC)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .supply_ok(supply_ok), .batt_low(batt_low), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        idle(4);
        we_n = 1'b1;
        idle(4);
        ce_n = 1'b1;
        idle(4);
    endtask

    task automatic do_read(input logic [10:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        idle(5);
        d = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(4);
    endtask

    task automatic power_cycle(input bit low_batt);
        @(negedge clk);
        supply_ok = 1'b0;
        idle(6);
        batt_low = low_batt;
        supply_ok = 1'b1;
        idle(REC + 8);
        batt_low = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * CLK_PERIOD);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        logic       en;

        // R8 reset state
        idle(3);
        check(locked == 1'b1, "R8 locked in reset", locked, 1);
        check(dout_en == 1'b0, "R8 no drive in reset", dout_en, 0);
        @(negedge clk) rst = 1'b0;
        idle(2);
        check(locked == 1'b1, "R8 locked after reset", locked, 1);
        idle(REC + 6);
        check(locked == 1'b0, "R7 unlocked after recovery", locked, 0);

        // R1 R2 vector table
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][19]) begin
                do_write(VEC[v][18:8], VEC[v][7:0]);
            end else begin
                do_read(VEC[v][18:8], rd, en);
                check(en == 1'b1, "R1 drive on read", en, 1);
                check(rd == VEC[v][7:0], "R1 read data", rd, VEC[v][7:0]);
            end
        end

        // R1 output gate high: no drive
        @(negedge clk) addr = 11'h7FF; ce_n = 1'b0; oe_n = 1'b1;
        idle(5);
        check(dout_en == 1'b0, "R1 oe high no drive", dout_en, 0);
        ce_n = 1'b1; idle(4);

        // R2 write with oe low held
        @(negedge clk) oe_n = 1'b0;
        do_write(11'h055, 8'hC3);
        @(negedge clk) oe_n = 1'b1;
        do_read(11'h055, rd, en);
        check(rd == 8'hC3, "R2 oe ignored on write", rd, 8'hC3);

        // R3 data changed mid-write and after a select-ended close
        @(negedge clk) addr = 11'h2AA; din = 8'h01; we_n = 1'b0;
        idle(4);
        ce_n = 1'b0; idle(4);
        din = 8'h02; idle(4);
        ce_n = 1'b1; idle(1);
        din = 8'h03; idle(4);
        we_n = 1'b1; idle(4);
        do_read(11'h2AA, rd, en);
        check(rd == 8'h02, "R3 last open-window data", rd, 8'h02);

        // R4 strobe low while driving
        @(negedge clk) addr = 11'h123; din = 8'h77; ce_n = 1'b0; oe_n = 1'b0;
        idle(5);
        check(dout_en == 1'b1, "R4 driving before strobe", dout_en, 1);
        we_n = 1'b0; idle(4);
        check(dout_en == 1'b0, "R4 strobe kills drive", dout_en, 0);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; idle(4);

        // R9 select high: strobe pulses store nothing
        @(negedge clk) addr = 11'h7FF; din = 8'hEE; oe_n = 1'b0; we_n = 1'b0;
        idle(6);
        check(dout_en == 1'b0, "R9 deselected no drive", dout_en, 0);
        we_n = 1'b1; oe_n = 1'b1; idle(4);
        do_read(11'h7FF, rd, en);
        check(rd == 8'h5A, "R9 no write when deselected", rd, 8'h5A);

        // R5 supply fail: locked, quiet, writes ignored
        @(negedge clk) supply_ok = 1'b0;
        idle(4);
        check(locked == 1'b1, "R5 locked on fail", locked, 1);
        do_write(11'h400, 8'h99);
        @(negedge clk) addr = 11'h400; ce_n = 1'b0; oe_n = 1'b0;
        idle(5);
        check(dout_en == 1'b0, "R5 no drive on fail", dout_en, 0);
        // R7 return with both pins low: stays locked
        we_n = 1'b0; supply_ok = 1'b1;
        idle(REC + 20);
        check(locked == 1'b1, "R7 held low keeps lock", locked, 1);
        we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
        idle(REC - 2);
        check(locked == 1'b1, "R7 lock before count ends", locked, 1);
        idle(8);
        check(locked == 1'b0, "R7 unlock after count", locked, 0);
        do_read(11'h400, rd, en);
        check(rd == 8'h00, "R5 contents kept, fail write ignored", rd, 8'h00);
        do_read(11'h000, rd, en);
        check(rd == 8'h11, "R5 contents kept", rd, 8'h11);

        // R6 battery-low blocks exactly one write
        power_cycle(1'b1);
        check(locked == 1'b0, "R6 unlocked after recovery", locked, 0);
        do_write(11'h123, 8'h44);
        do_read(11'h123, rd, en);
        check(rd == 8'h77, "R6 first write discarded", rd, 8'h77);
        do_write(11'h123, 8'h45);
        do_read(11'h123, rd, en);
        check(rd == 8'h45, "R6 second write stored", rd, 8'h45);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule